// File: doc/BRIEF.md
# Four-Slot Transmit Descriptor Engine

This block drives frames out of a network transmit path from four fixed descriptor slots. Each slot holds a buffer address and a command/status word. Software first writes a slot's buffer address and then its command word, which holds the frame length and an early-start threshold. Writing the command word launches the slot. The engine serves slots strictly in rotating order. For each slot it reads the frame one byte at a time through a simple fetch port into an internal byte buffer. It then streams the bytes to the transmit path through a valid/ready handshake, and writes the outcome back into the same status word.

The MAC reports its result with a one-cycle pulse after the last byte has been handed over. That result carries the collision count, heartbeat failure, late collision, abort and carrier-loss flags. The engine records it in the slot and raises a one-cycle transmit-OK or transmit-error event. A system interrupt status register sets bit 2 on the OK event and bit 3 on the error event. If the buffer runs dry after streaming has begun, the frame is dropped and recorded as an underrun.

Top module: `tx_desc_engine`

## Requirements
- R1: After reset every status word reads 0x0000_2000 (only ownership set), every address register reads 0, and neither fetch_req nor tx_valid is high.
- R2: Slot i's status word is at register offset 0x10+4*i and its address register at 0x20+4*i. Read data appears on reg_rd_data one cycle after reg_rd_en. The status layout is: size in bits 12:0, ownership bit 13, underrun bit 14, transmit-OK bit 15, threshold bits 20:16, collision count bits 27:24, heartbeat fail bit 28, late collision bit 29, abort bit 30, carrier lost bit 31, and bits 23:21 read 0. A command write stores size and threshold and clears every other field, including ownership.
- R3: A launched slot fetches exactly size bytes, starting at its buffer address and incrementing by one per accepted byte. The same bytes leave on tx_data in the same order, with tx_last on the final byte only.
- R4: The first byte is not offered to the transmit path until threshold*32 bytes have been fetched. If the frame is shorter than that, the first byte waits until the whole frame has been fetched.
- R5: The ownership bit returns to 1 as soon as the last byte of the frame has been fetched, before the MAC result arrives.
- R6: On mac_done without abort, the slot records the MAC result fields and sets transmit-OK. tx_ok_irq pulses once.
- R7: On mac_done with abort, the abort bit is recorded, transmit-OK stays clear, and tx_err_irq pulses once.
- R8: An underrun occurs when, after streaming has begun, tx_ready is high while the byte buffer is empty. The frame is then dropped without tx_last, the slot shows ownership and underrun with transmit-OK clear, and tx_err_irq pulses once.
- R9: Slots are served only in the order 0,1,2,3,0,…. A slot launched out of turn waits until every earlier slot in the rotation has been launched and served.
- R10: Slots launched while the engine is busy are queued and served back to back after the current frame, in rotation order.
- R11: A command write to the slot currently being served is ignored. The size in flight and the recorded size are unchanged, and no extra frame follows.
- R12: A slot launched with size 0 completes at once with ownership and transmit-OK set (0x0000_A000 for threshold 0), sends no byte, and pulses tx_ok_irq.
- R13: While tx_valid is high and tx_ready is low, tx_valid, tx_data and tx_last hold their values.
- R14: tx_ok_irq and tx_err_irq are never high together, and each lasts one cycle per completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 8 | Register write offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_en | input | 1 | Register read strobe |
| reg_rd_addr | input | 8 | Register read offset |
| reg_rd_data | output | 32 | Registered read data |
| fetch_req | output | 1 | Engine wants a frame byte |
| fetch_addr | output | 32 | Byte address being fetched |
| fetch_valid | input | 1 | Memory supplies fetch_data this cycle |
| fetch_data | input | 8 | Fetched byte |
| tx_valid | output | 1 | Byte offered to the transmit path |
| tx_data | output | 8 | Offered byte |
| tx_last | output | 1 | Offered byte is the final one of the frame |
| tx_ready | input | 1 | Transmit path takes the byte |
| mac_done | input | 1 | One-cycle frame-end result strobe |
| mac_coll_cnt | input | 4 | Collision count of the frame |
| mac_hb_fail | input | 1 | Heartbeat check failed |
| mac_late_coll | input | 1 | Collision outside the window |
| mac_abort | input | 1 | MAC aborted the frame |
| mac_carrier_lost | input | 1 | Carrier dropped during the frame |
| tx_ok_irq | output | 1 | One-cycle transmit-OK event |
| tx_err_irq | output | 1 | One-cycle transmit-error event |

## Verification
The bench first sweeps frame lengths 1 to 40 against thresholds 0, 1 and 2 with a fetch port that never stalls. This pins down byte order, the tx_last position and the exact status word for short frames on both sides of the threshold. A fetch port that stalls every other cycle then separates the two threshold outcomes. A low threshold starts early and underruns, while a threshold above the frame length waits for the whole frame and completes cleanly. Toggling tx_ready tests that the stream holds still when the path is not ready. Out-of-turn launches, a burst of four queued launches, a rewrite of the active slot and a zero-length slot expose the rotation, queueing and ignore rules.

// File: rtl/tx_desc_pkg.sv
package tx_desc_pkg;
  localparam int SZ_W  = 13;
  localparam int THR_W = 5;
  localparam int NCC_W = 4;

  typedef struct packed {
    logic             crs_lost;
    logic             aborted;
    logic             late_coll;
    logic             hb_fail;
    logic [NCC_W-1:0] coll_cnt;
  } mac_res_t;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_RUN,
    ENG_WAIT_MAC,
    ENG_FINISH
  } eng_state_t;

  function automatic logic [31:0] pack_status(
    input logic [SZ_W-1:0]  size,
    input logic [THR_W-1:0] thr,
    input logic             own,
    input logic             tun,
    input logic             tok,
    input mac_res_t         res
  );
    return {res.crs_lost, res.aborted, res.late_coll, res.hb_fail, res.coll_cnt,
            3'b000, thr, tok, tun, own, size};
  endfunction
endpackage

// File: rtl/tx_byte_fifo.sv
module tx_byte_fifo #(
  parameter int DEPTH = 1024,
  parameter int W     = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clr,
  input  logic                        push,
  input  logic [W-1:0]                din,
  input  logic                        pop,
  output logic [W-1:0]                dout,
  output logic [$clog2(DEPTH+1)-1:0]  count,
  output logic                        empty,
  output logic                        full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= wp + AW'(1);
      if (pop_ok)  rp <= rp + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/tx_slot_regs.sv
module tx_slot_regs
  import tx_desc_pkg::*;
#(
  parameter int            NSLOT     = 4,
  parameter int            RA_W      = 8,
  parameter logic [7:0]    STAT_BASE = 8'h10,
  parameter logic [7:0]    ADDR_BASE = 8'h20
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [RA_W-1:0]                   wr_addr,
  input  logic [31:0]                       wr_data,
  input  logic                              rd_en,
  input  logic [RA_W-1:0]                   rd_addr,
  output logic [31:0]                       rd_data,
  input  logic                              act_vld,
  input  logic [$clog2(NSLOT)-1:0]          cur_idx,
  input  logic                              take,
  input  logic                              own_set,
  input  logic                              done,
  input  logic                              done_tun,
  input  logic                              done_tok,
  input  mac_res_t                          done_res,
  output logic [NSLOT-1:0]                  pend,
  output logic [NSLOT-1:0]                  stat_acc,
  output logic [NSLOT-1:0][SZ_W-1:0]        slot_size,
  output logic [NSLOT-1:0][THR_W-1:0]       slot_thr,
  output logic [NSLOT-1:0][31:0]            slot_addr
);
  localparam int IDX_W = $clog2(NSLOT);

  logic [NSLOT-1:0]   own_q, tun_q, tok_q;
  mac_res_t [NSLOT-1:0] res_q;
  logic [NSLOT-1:0]   stat_hit, addr_hit;
  logic [31:0]        rd_mux;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic is_cur;
    assign is_cur      = (cur_idx == IDX_W'(i));
    assign stat_hit[i] = wr_en && (wr_addr == RA_W'(int'(STAT_BASE) + 4*i));
    assign addr_hit[i] = wr_en && (wr_addr == RA_W'(int'(ADDR_BASE) + 4*i));
    assign stat_acc[i] = stat_hit[i] && !(act_vld && is_cur);

    always_ff @(posedge clk) begin
      if (rst) begin
        slot_addr[i] <= '0;
        slot_size[i] <= '0;
        slot_thr[i]  <= '0;
        own_q[i]     <= 1'b1;
        tun_q[i]     <= 1'b0;
        tok_q[i]     <= 1'b0;
        res_q[i]     <= '0;
        pend[i]      <= 1'b0;
      end else begin
        if (addr_hit[i]) slot_addr[i] <= wr_data;
        if (stat_acc[i]) begin
          slot_size[i] <= wr_data[SZ_W-1:0];
          slot_thr[i]  <= wr_data[16 +: THR_W];
          own_q[i]     <= 1'b0;
          tun_q[i]     <= 1'b0;
          tok_q[i]     <= 1'b0;
          res_q[i]     <= '0;
          pend[i]      <= 1'b1;
        end else begin
          if (take && is_cur)    pend[i]  <= 1'b0;
          if (own_set && is_cur) own_q[i] <= 1'b1;
          if (done && is_cur) begin
            own_q[i] <= 1'b1;
            tun_q[i] <= done_tun;
            tok_q[i] <= done_tok;
            res_q[i] <= done_res;
          end
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (rd_addr == RA_W'(int'(STAT_BASE) + 4*i))
        rd_mux = pack_status(slot_size[i], slot_thr[i], own_q[i], tun_q[i], tok_q[i], res_q[i]);
      if (rd_addr == RA_W'(int'(ADDR_BASE) + 4*i))
        rd_mux = slot_addr[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/tx_engine.sv
module tx_engine
  import tx_desc_pkg::*;
#(
  parameter int NSLOT      = 4,
  parameter int FIFO_DEPTH = 1024
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NSLOT-1:0]               pend,
  input  logic [NSLOT-1:0]               stat_acc,
  input  logic [NSLOT-1:0][SZ_W-1:0]     slot_size,
  input  logic [NSLOT-1:0][THR_W-1:0]    slot_thr,
  input  logic [NSLOT-1:0][31:0]         slot_addr,
  output logic                           fetch_req,
  output logic [31:0]                    fetch_addr,
  input  logic                           fetch_valid,
  input  logic [7:0]                     fetch_data,
  output logic                           tx_valid,
  output logic [7:0]                     tx_data,
  output logic                           tx_last,
  input  logic                           tx_ready,
  input  logic                           mac_done,
  input  mac_res_t                       mac_res,
  output logic                           act_vld,
  output logic [$clog2(NSLOT)-1:0]       cur_idx,
  output logic                           take,
  output logic                           own_set,
  output logic                           done,
  output logic                           done_tun,
  output logic                           done_tok,
  output mac_res_t                       done_res,
  output logic                           tok_irq,
  output logic                           ter_irq
);
  localparam int IDX_W = $clog2(NSLOT);
  localparam int CW    = $clog2(FIFO_DEPTH+1);

  eng_state_t       state;
  logic [SZ_W-1:0]  size_r, f_cnt, s_cnt;
  logic [THR_W-1:0] thr_r;
  logic             started, fdone;
  logic [CW-1:0]    fifo_cnt;
  logic             fifo_empty, fifo_full;
  logic             push, pop, last_fetch, start_ok, underrun;
  logic [IDX_W-1:0] nxt_idx;

  assign act_vld    = (state != ENG_IDLE);
  assign take       = (state == ENG_IDLE) && pend[cur_idx] && !stat_acc[cur_idx];
  assign fetch_req  = (state == ENG_RUN) && !fdone && !fifo_full;
  assign push       = fetch_req && fetch_valid;
  assign last_fetch = (f_cnt + SZ_W'(1)) == size_r;
  assign own_set    = push && last_fetch;
  assign tx_valid   = (state == ENG_RUN) && started && !fifo_empty;
  assign tx_last    = tx_valid && (s_cnt == size_r - SZ_W'(1));
  assign pop        = tx_valid && tx_ready;
  assign underrun   = (state == ENG_RUN) && started && tx_ready && fifo_empty;
  assign start_ok   = fdone || (32'(fifo_cnt) >= (32'(thr_r) << 5));
  assign nxt_idx    = (cur_idx == IDX_W'(NSLOT-1)) ? '0 : cur_idx + IDX_W'(1);

  assign done     = underrun || ((state == ENG_WAIT_MAC) && mac_done) || (state == ENG_FINISH);
  assign done_tun = (state == ENG_RUN);
  assign done_tok = (state == ENG_FINISH) || ((state == ENG_WAIT_MAC) && !mac_res.aborted);
  assign done_res = (state == ENG_WAIT_MAC) ? mac_res : '0;

  tx_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .clr   (done),
    .push  (push),
    .din   (fetch_data),
    .pop   (pop),
    .dout  (tx_data),
    .count (fifo_cnt),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ENG_IDLE;
      cur_idx    <= '0;
      fetch_addr <= '0;
      size_r     <= '0;
      thr_r      <= '0;
      f_cnt      <= '0;
      s_cnt      <= '0;
      started    <= 1'b0;
      fdone      <= 1'b0;
      tok_irq    <= 1'b0;
      ter_irq    <= 1'b0;
    end else begin
      tok_irq <= done && done_tok;
      ter_irq <= done && !done_tok;
      case (state)
        ENG_IDLE: if (take) begin
          fetch_addr <= slot_addr[cur_idx];
          size_r     <= slot_size[cur_idx];
          thr_r      <= slot_thr[cur_idx];
          f_cnt      <= '0;
          s_cnt      <= '0;
          started    <= 1'b0;
          fdone      <= 1'b0;
          state      <= (slot_size[cur_idx] == '0) ? ENG_FINISH : ENG_RUN;
        end
        ENG_RUN: begin
          if (push) begin
            fetch_addr <= fetch_addr + 32'd1;
            f_cnt      <= f_cnt + SZ_W'(1);
            if (last_fetch) fdone <= 1'b1;
          end
          if (!started && start_ok) started <= 1'b1;
          if (pop) begin
            s_cnt <= s_cnt + SZ_W'(1);
            if (tx_last) state <= ENG_WAIT_MAC;
          end
        end
        default: ;
      endcase
      if (done) begin
        state   <= ENG_IDLE;
        cur_idx <= nxt_idx;
      end
    end
  end
endmodule

// File: rtl/tx_desc_engine.sv
module tx_desc_engine
  import tx_desc_pkg::*;
#(
  parameter int         NSLOT      = 4,
  parameter int         FIFO_DEPTH = 1024,
  parameter logic [7:0] STAT_BASE  = 8'h10,
  parameter logic [7:0] ADDR_BASE  = 8'h20
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr_en,
  input  logic [7:0]  reg_wr_addr,
  input  logic [31:0] reg_wr_data,
  input  logic        reg_rd_en,
  input  logic [7:0]  reg_rd_addr,
  output logic [31:0] reg_rd_data,
  output logic        fetch_req,
  output logic [31:0] fetch_addr,
  input  logic        fetch_valid,
  input  logic [7:0]  fetch_data,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        tx_ready,
  input  logic        mac_done,
  input  logic [3:0]  mac_coll_cnt,
  input  logic        mac_hb_fail,
  input  logic        mac_late_coll,
  input  logic        mac_abort,
  input  logic        mac_carrier_lost,
  output logic        tx_ok_irq,
  output logic        tx_err_irq
);
  localparam int IDX_W = $clog2(NSLOT);

  logic [NSLOT-1:0]            pend, stat_acc;
  logic [NSLOT-1:0][SZ_W-1:0]  slot_size;
  logic [NSLOT-1:0][THR_W-1:0] slot_thr;
  logic [NSLOT-1:0][31:0]      slot_addr;
  logic                        act_vld, take, own_set, done, done_tun, done_tok;
  logic [IDX_W-1:0]            cur_idx;
  mac_res_t                    mac_res, done_res;

  assign mac_res = '{crs_lost: mac_carrier_lost, aborted: mac_abort,
                     late_coll: mac_late_coll, hb_fail: mac_hb_fail,
                     coll_cnt: mac_coll_cnt};

  tx_slot_regs #(
    .NSLOT(NSLOT), .RA_W(8), .STAT_BASE(STAT_BASE), .ADDR_BASE(ADDR_BASE)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (reg_wr_en),
    .wr_addr   (reg_wr_addr),
    .wr_data   (reg_wr_data),
    .rd_en     (reg_rd_en),
    .rd_addr   (reg_rd_addr),
    .rd_data   (reg_rd_data),
    .act_vld   (act_vld),
    .cur_idx   (cur_idx),
    .take      (take),
    .own_set   (own_set),
    .done      (done),
    .done_tun  (done_tun),
    .done_tok  (done_tok),
    .done_res  (done_res),
    .pend      (pend),
    .stat_acc  (stat_acc),
    .slot_size (slot_size),
    .slot_thr  (slot_thr),
    .slot_addr (slot_addr)
  );

  tx_engine #(.NSLOT(NSLOT), .FIFO_DEPTH(FIFO_DEPTH)) u_eng (
    .clk         (clk),
    .rst         (rst),
    .pend        (pend),
    .stat_acc    (stat_acc),
    .slot_size   (slot_size),
    .slot_thr    (slot_thr),
    .slot_addr   (slot_addr),
    .fetch_req   (fetch_req),
    .fetch_addr  (fetch_addr),
    .fetch_valid (fetch_valid),
    .fetch_data  (fetch_data),
    .tx_valid    (tx_valid),
    .tx_data     (tx_data),
    .tx_last     (tx_last),
    .tx_ready    (tx_ready),
    .mac_done    (mac_done),
    .mac_res     (mac_res),
    .act_vld     (act_vld),
    .cur_idx     (cur_idx),
    .take        (take),
    .own_set     (own_set),
    .done        (done),
    .done_tun    (done_tun),
    .done_tok    (done_tok),
    .done_res    (done_res),
    .tok_irq     (tx_ok_irq),
    .ter_irq     (tx_err_irq)
  );
endmodule

// File: rtl/tx_desc_engine_chk.sv
module tx_desc_engine_chk (
  input logic        clk,
  input logic        rst,
  input logic        fetch_req,
  input logic        fetch_valid,
  input logic [31:0] fetch_addr,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic        tx_last,
  input logic [7:0]  tx_data,
  input logic        tx_ok_irq,
  input logic        tx_err_irq
);
  p_irq_excl_r14: assert property (@(posedge clk) disable iff (rst)
    !(tx_ok_irq && tx_err_irq));

  p_ok_pulse_r14: assert property (@(posedge clk) disable iff (rst)
    tx_ok_irq |=> !tx_ok_irq);

  p_err_pulse_r14: assert property (@(posedge clk) disable iff (rst)
    tx_err_irq |=> !tx_err_irq);

  p_hold_r13: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  p_fetch_step_r3: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && fetch_valid) |=> (fetch_addr == $past(fetch_addr) + 32'd1));

  p_last_valid_r3: assert property (@(posedge clk) disable iff (rst)
    tx_last |-> tx_valid);
endmodule

bind tx_desc_engine tx_desc_engine_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .fetch_req   (fetch_req),
  .fetch_valid (fetch_valid),
  .fetch_addr  (fetch_addr),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .tx_last     (tx_last),
  .tx_data     (tx_data),
  .tx_ok_irq   (tx_ok_irq),
  .tx_err_irq  (tx_err_irq)
);

// File: tb/tb_tx_desc_engine.sv
`timescale 1ns/1ps
module tb_tx_desc_engine;
  localparam logic [7:0] STAT = 8'h10;
  localparam logic [7:0] ADR  = 8'h20;
  localparam logic [31:0] OWN = 32'h0000_2000;
  localparam logic [31:0] TUN = 32'h0000_4000;
  localparam logic [31:0] TOK = 32'h0000_8000;

  logic clk = 0, rst = 1;
  logic reg_wr_en = 0, reg_rd_en = 0;
  logic [7:0] reg_wr_addr = 0, reg_rd_addr = 0;
  logic [31:0] reg_wr_data = 0, reg_rd_data;
  logic fetch_req, fetch_valid;
  logic [31:0] fetch_addr;
  logic [7:0] fetch_data;
  logic tx_valid, tx_last, tx_ready;
  logic [7:0] tx_data;
  logic mac_done = 0, mac_hb_fail = 0, mac_late_coll = 0, mac_abort = 0, mac_carrier_lost = 0;
  logic [3:0] mac_coll_cnt = 0;
  logic tx_ok_irq, tx_err_irq;

  logic fetch_gate = 1, ready_q = 1, stall = 0, rtoggle = 0;

  int checks = 0, fails = 0, cyc = 0;
  int got = 0, flen = 0, fcount = 0, first_fc = 0, ok_cnt = 0, err_cnt = 0;
  bit last_seen = 0, seen_first = 0;
  logic [7:0] rx [512];
  int nxt = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  assign fetch_valid = fetch_req & fetch_gate;
  assign fetch_data  = mem_byte(fetch_addr);
  assign tx_ready    = ready_q;

  tx_desc_engine dut (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_en(reg_rd_en), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_valid(fetch_valid), .fetch_data(fetch_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .mac_done(mac_done), .mac_coll_cnt(mac_coll_cnt), .mac_hb_fail(mac_hb_fail),
    .mac_late_coll(mac_late_coll), .mac_abort(mac_abort), .mac_carrier_lost(mac_carrier_lost),
    .tx_ok_irq(tx_ok_irq), .tx_err_irq(tx_err_irq)
  );

  always @(posedge clk) begin
    #2;
    fetch_gate <= stall ? ~fetch_gate : 1'b1;
    ready_q    <= rtoggle ? ~ready_q : 1'b1;
  end

  always @(negedge clk) begin
    if (tx_valid && !seen_first) begin seen_first = 1; first_fc = fcount; end
    if (fetch_req && fetch_valid) fcount++;
    if (tx_valid && tx_ready) begin
      if (got < 512) rx[got] = tx_data;
      got++;
      if (tx_last) begin flen = got; last_seen = 1; got = 0; end
    end
    if (tx_ok_irq)  ok_cnt++;
    if (tx_err_irq) err_cnt++;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", rq, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr_en = 1; reg_wr_addr = a; reg_wr_data = d;
    tick(1);
    reg_wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_rd_en = 1; reg_rd_addr = a;
    tick(1);
    reg_rd_en = 0;
    d = reg_rd_data;
  endtask

  task automatic arm();
    got = 0; flen = 0; last_seen = 0; seen_first = 0; fcount = 0;
  endtask

  function automatic logic [31:0] exp_stat(input int size, input int thr, input bit tok, input bit tun,
      input logic [3:0] ncc, input bit hb, input bit owc, input bit abt, input bit crs);
    return {crs, abt, owc, hb, ncc, 3'b000, 5'(thr), tok, tun, 1'b1, 13'(size)};
  endfunction

  task automatic close_frame(input int slot, input logic [31:0] base, input int size, input int thr,
      input bit abt, input logic [3:0] ncc, input bit hb, input bit owc, input bit crs, input string rq);
    int n = 0, bad = 0, ok0, er0;
    logic [31:0] st;
    while (!last_seen && n < 5000) begin tick(1); n++; end
    chk(last_seen && flen == size, {rq, " frame length"}, flen, size);
    for (int k = 0; k < size && k < 512; k++)
      if (rx[k] !== mem_byte(base + k)) bad++;
    chk(bad == 0, {rq, " byte content"}, bad, 0);
    last_seen = 0;
    ok0 = ok_cnt; er0 = err_cnt;
    tick(2);
    mac_done = 1; mac_abort = abt; mac_coll_cnt = ncc; mac_hb_fail = hb;
    mac_late_coll = owc; mac_carrier_lost = crs;
    tick(1);
    mac_done = 0; mac_abort = 0; mac_coll_cnt = 0; mac_hb_fail = 0;
    mac_late_coll = 0; mac_carrier_lost = 0;
    tick(2);
    chk((ok_cnt - ok0) == int'(!abt) && (err_cnt - er0) == int'(abt), {rq, " R6/R7 irq events"},
        (ok_cnt - ok0) * 16 + (err_cnt - er0), int'(!abt) * 16 + int'(abt));
    rd(STAT + 8'(4 * slot), st);
    chk(st == exp_stat(size, thr, !abt, 0, ncc, hb, owc, abt, crs), {rq, " R2 status word"},
        st, exp_stat(size, thr, !abt, 0, ncc, hb, owc, abt, crs));
  endtask

  task automatic send(input logic [31:0] base, input int size, input int thr, input bit abt,
      input logic [3:0] ncc, input bit hb, input bit owc, input bit crs, input string rq);
    int lim;
    arm();
    wr(ADR + 8'(4 * nxt), base);
    wr(STAT + 8'(4 * nxt), (32'(thr) << 16) | 32'(size));
    close_frame(nxt, base, size, thr, abt, ncc, hb, owc, crs, rq);
    lim = (thr * 32 < size) ? thr * 32 : size;
    chk(first_fc >= lim, "R4 start threshold", first_fc, lim);
    nxt = (nxt + 1) % 4;
  endtask

  initial begin
    logic [31:0] v;
    int n, e0, o0, s1;
    tick(3);
    rst = 0;
    tick(1);

    // R1 reset state
    chk(!tx_valid && !fetch_req, "R1 idle outputs", {30'b0, tx_valid, fetch_req}, 0);
    for (int i = 0; i < 4; i++) begin
      rd(STAT + 8'(4 * i), v); chk(v == OWN, "R1 status reset", v, OWN);
      rd(ADR + 8'(4 * i), v);  chk(v == 0, "R1 address reset", v, 0);
    end

    // R3 R4 R6: sweep lengths and thresholds, fetch never stalls
    for (int t = 0; t < 3; t++)
      for (int s = 1; s <= 40; s++)
        send(32'h1000 + 32'(s * 97 + t * 7), s, t, 0, 4'(s % 16), s[1], s[2], s[0], "R3 sweep");

    // R7 abort
    send(32'h4400, 20, 0, 1, 4'hF, 1, 1, 0, "R7 abort");

    // R13 ready toggling
    rtoggle = 1;
    send(32'h5000, 37, 0, 0, 4'h2, 0, 0, 0, "R13 held stream");
    rtoggle = 0; tick(2);

    // R9 strict rotation: out-of-turn slot waits
    s1 = (nxt + 1) % 4;
    arm();
    wr(ADR + 8'(4 * s1), 32'h6100);
    wr(STAT + 8'(4 * s1), 32'd8);
    tick(40);
    chk(fcount == 0 && !tx_valid, "R9 out-of-turn slot waits", fcount, 0);
    wr(ADR + 8'(4 * nxt), 32'h6000);
    wr(STAT + 8'(4 * nxt), 32'd6);
    close_frame(nxt, 32'h6000, 6, 0, 0, 4'h1, 0, 0, 0, "R9 turn slot first");
    close_frame(s1, 32'h6100, 8, 0, 0, 4'h0, 0, 0, 0, "R9 later slot second");
    nxt = (nxt + 2) % 4;

    // R10 burst of four queued launches
    arm();
    for (int k = 0; k < 4; k++) begin
      wr(ADR + 8'(4 * ((nxt + k) % 4)), 32'h7000 + 32'(k * 256));
      wr(STAT + 8'(4 * ((nxt + k) % 4)), 32'(5 + 3 * k));
    end
    for (int k = 0; k < 4; k++)
      close_frame((nxt + k) % 4, 32'h7000 + 32'(k * 256), 5 + 3 * k, 0, 0, 4'(k), 0, 0, 0, "R10 queued order");

    // R2 R5 R11: ownership and rewrite of the active slot
    arm();
    wr(ADR + 8'(4 * nxt), 32'h8000);
    wr(STAT + 8'(4 * nxt), (32'd31 << 16) | 32'd300);
    tick(3);
    rd(STAT + 8'(4 * nxt), v);
    chk(v == ((32'd31 << 16) | 32'd300), "R2 launch clears ownership", v, (32'd31 << 16) | 32'd300);
    wr(STAT + 8'(4 * nxt), 32'd5);
    n = 0;
    while (fcount < 300 && n < 2000) begin tick(1); n++; end
    tick(2);
    rd(STAT + 8'(4 * nxt), v);
    chk(v == ((32'd31 << 16) | 32'd300 | OWN), "R5 R11 ownership back, size kept", v,
        (32'd31 << 16) | 32'd300 | OWN);
    close_frame(nxt, 32'h8000, 300, 31, 0, 4'h3, 0, 0, 1, "R11 original frame");
    tick(20);
    chk(!tx_valid && fcount == 300, "R11 no extra frame", fcount, 300);
    nxt = (nxt + 1) % 4;

    // R8 underrun with stalled fetch and low threshold
    stall = 1;
    arm();
    e0 = err_cnt;
    wr(ADR + 8'(4 * nxt), 32'h9000);
    wr(STAT + 8'(4 * nxt), (32'd1 << 16) | 32'd100);
    n = 0;
    while (err_cnt == e0 && n < 3000) begin tick(1); n++; end
    tick(2);
    chk(err_cnt - e0 == 1, "R8 error event", err_cnt - e0, 1);
    chk(!last_seen, "R8 no tx_last", {31'b0, last_seen}, 0);
    chk(first_fc >= 32, "R4 threshold before underrun", first_fc, 32);
    rd(STAT + 8'(4 * nxt), v);
    chk(v == ((32'd1 << 16) | 32'd100 | OWN | TUN), "R8 underrun status", v,
        (32'd1 << 16) | 32'd100 | OWN | TUN);
    nxt = (nxt + 1) % 4;

    // R4 high threshold with stalled fetch: waits for whole frame
    send(32'hA000, 100, 4, 0, 4'h0, 0, 0, 0, "R4 full prefetch");
    chk(first_fc == 100, "R4 waits for whole frame", first_fc, 100);
    stall = 0; tick(2);

    // R12 zero-length slot
    arm();
    o0 = ok_cnt;
    wr(STAT + 8'(4 * nxt), 32'd0);
    tick(6);
    chk(ok_cnt - o0 == 1 && got == 0 && fcount == 0, "R12 zero length completes", ok_cnt - o0, 1);
    rd(STAT + 8'(4 * nxt), v);
    chk(v == (OWN | TOK), "R12 zero length status", v, OWN | TOK);
    nxt = (nxt + 1) % 4;

    // rotation still intact after all cases
    send(32'hB000, 12, 0, 0, 4'h5, 0, 0, 0, "R9 rotation after corner cases");

    summary();
    $finish;
  end
endmodule